// File: doc/BRIEF.md
# Destination-Based Frame Forwarding Classifier

This block serves the receive side of a two-port Ethernet switch element. Each port hands it the leading bytes of every arriving frame. From the first six valid bytes it builds the 48-bit destination MAC address and compares that address against a shared 32-entry content-addressable table. It then issues a one-cycle decision strobe that carries one of four forwarding actions: deliver locally, relay to the opposite port, do both, or drop.

Each table entry holds a valid flag, an address and an action. Unicast addresses that hit an entry take that entry's action. Unicast addresses that miss every entry take a per-port miss action. Group addresses (broadcast and multicast) skip the table and take a per-port flood action. Two per-port enables then trim the result. One enable covers relaying out of the port. The other covers local delivery at the port.

The decision comes out a fixed time after the sixth address byte arrives, well before the end of any legal frame. Framing, DMA and frame storage sit outside this block.

Top module: `dst_fwd_classifier`

## Requirements
- R1: On each port the address is built from the first six bytes that are sampled with `rx_vld_i` high, starting with a byte that has both `rx_sof_i` and `rx_vld_i` high. The first byte becomes bits 47:40. Bytes seen before any start marker do not count, and neither does a start marker sampled while `rx_vld_i` is low.
- R2: If the sixth byte is sampled on clock edge k, `dec_vld_o[p]` is registered high on edge k+2 and stays high for exactly one cycle.
- R3: Bytes that arrive after the sixth one, up to the next start marker, produce no further decision. A start marker received partway through an address discards the partial address and begins a new one.
- R4: Actions are 2-bit codes. Bit 0 requests local delivery and bit 1 requests relay, so 00 is drop, 01 is local, 10 is relay and 11 is both. `dec_act_o[2p+1:2p]` carries the action for port p.
- R5: A unicast address (bit 40 = 0) that equals the address of a valid entry takes that entry's action. When several valid entries match, the lowest index wins.
- R6: A unicast address that matches no valid entry takes `miss_act_i[2p+1:2p]`. An entry whose valid flag is 0 never matches.
- R7: A group address (bit 40 = 1) takes `flood_act_i[2p+1:2p]` whatever the table holds.
- R8: When `relay_en_i[p]` is 0, a relay or both action becomes local. Drop and local are unchanged.
- R9: When `local_en_i[p]` is 0, bit 0 of the action is cleared after R8 is applied. Local becomes drop and both becomes relay, so with both enables low every action is drop.
- R10: A clock edge with `cam_we_i` high writes `cam_valid_i`, `cam_mac_i` and `cam_act_i` into the entry selected by `cam_idx_i`. Reset clears every valid flag.
- R11: The two ports classify independently, even in the same cycle, and each uses only its own configuration bits. Configuration is held stable from the sixth byte until the decision.
- R12: While reset is asserted and after it is released, `dec_vld_o` stays 0 until a full address has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_sof_i | input | 2 | Per-port first-byte marker |
| rx_vld_i | input | 2 | Per-port byte valid |
| rx_byte_i | input | 16 | Per-port byte, port p in bits 8p+7:8p |
| cam_we_i | input | 1 | Table entry write strobe |
| cam_idx_i | input | 5 | Entry index to write |
| cam_valid_i | input | 1 | Valid flag to write |
| cam_mac_i | input | 48 | Address to write |
| cam_act_i | input | 2 | Action to write |
| miss_act_i | input | 4 | Per-port action for a unicast miss |
| flood_act_i | input | 4 | Per-port action for group addresses |
| relay_en_i | input | 2 | Per-port relay enable |
| local_en_i | input | 2 | Per-port local delivery enable |
| dec_vld_o | output | 2 | Per-port decision strobe |
| dec_act_o | output | 4 | Per-port decision action |

## Verification
The assertions check on every cycle that each decision strobe lasts one cycle and follows its address completion by exactly two edges. They also check that no strobe appears without a completed address, and that a cleared relay or local enable never lets the matching action bit through. The bench scenarios alone can show that the action is correct. That covers lowest-index priority among duplicate entries, invalid entries being skipped, group addresses overriding table hits, the reset clearing the table, restarts partway through an address, and the two ports running at once with different settings.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int ACT_W     = 2;
  localparam int LOCAL_BIT = 0;
  localparam logic [ACT_W-1:0] ACT_DROP  = 2'b00;
  localparam logic [ACT_W-1:0] ACT_LOCAL = 2'b01;

  // relay gating first, then local gating
  function automatic logic [ACT_W-1:0] dfc_gate(logic [ACT_W-1:0] act,
                                                 logic relay_en, logic local_en);
    logic [ACT_W-1:0] r;
    r = act;
    if (!relay_en && act != ACT_DROP) r = ACT_LOCAL;
    if (!local_en) r[LOCAL_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/dfc_addr_capture.sv
module dfc_addr_capture #(
  parameter int ADDR_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              vld_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              go_o
);
  localparam int N_BYTES = ADDR_W / 8;
  localparam int CNT_W   = $clog2(N_BYTES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              go_q;

  // cnt_q: 0 idle, 1..N_BYTES-1 collecting, N_BYTES done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
      go_q   <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (vld_i) begin
        if (sof_i) begin
          addr_q <= {addr_q[ADDR_W-9:0], byte_i};
          cnt_q  <= CNT_W'(1);
        end else if (cnt_q != '0 && cnt_q < CNT_W'(N_BYTES)) begin
          addr_q <= {addr_q[ADDR_W-9:0], byte_i};
          cnt_q  <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(N_BYTES - 1)) go_q <= 1'b1;
        end
      end
    end
  end

  assign addr_o = addr_q;
  assign go_o   = go_q;
endmodule

// File: rtl/dfc_cam_store.sv
module dfc_cam_store import dfc_pkg::*; #(
  parameter int NUM_ENTRIES = 32,
  parameter int ADDR_W      = 48,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] mac_i,
  input  logic [ACT_W-1:0]  act_i,
  output logic [NUM_ENTRIES-1:0] valid_o,
  output logic [ADDR_W-1:0] mac_o [NUM_ENTRIES],
  output logic [ACT_W-1:0]  act_o [NUM_ENTRIES]
);
  logic [NUM_ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]      mac_q [NUM_ENTRIES];
  logic [ACT_W-1:0]       act_q [NUM_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (we_i) valid_q[idx_i] <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mac_q[idx_i] <= mac_i;
      act_q[idx_i] <= act_i;
    end
  end

  assign valid_o = valid_q;
  assign mac_o   = mac_q;
  assign act_o   = act_q;
endmodule

// File: rtl/dfc_cam_match.sv
module dfc_cam_match import dfc_pkg::*; #(
  parameter int NUM_ENTRIES = 32,
  parameter int ADDR_W      = 48
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NUM_ENTRIES-1:0] valid_i,
  input  logic [ADDR_W-1:0]      mac_i [NUM_ENTRIES],
  input  logic [ACT_W-1:0]       act_i [NUM_ENTRIES],
  output logic                   hit_o,
  output logic [ACT_W-1:0]       act_o
);
  logic [NUM_ENTRIES-1:0] match;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    assign match[i] = valid_i[i] && (mac_i[i] == addr_i);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    act_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        act_o = act_i[i];
      end
    end
  end
endmodule

// File: rtl/dfc_action_resolve.sv
module dfc_action_resolve import dfc_pkg::*; (
  input  logic             hit_i,
  input  logic             mcast_i,
  input  logic [ACT_W-1:0] cam_act_i,
  input  logic [ACT_W-1:0] miss_act_i,
  input  logic [ACT_W-1:0] flood_act_i,
  input  logic             relay_en_i,
  input  logic             local_en_i,
  output logic [ACT_W-1:0] act_o
);
  logic [ACT_W-1:0] base;

  always_comb begin
    if (mcast_i)    base = flood_act_i;
    else if (hit_i) base = cam_act_i;
    else            base = miss_act_i;
    act_o = dfc_gate(base, relay_en_i, local_en_i);
  end
endmodule

// File: rtl/dst_fwd_classifier.sv
module dst_fwd_classifier import dfc_pkg::*; #(
  parameter int  NUM_ENTRIES = 32,
  parameter int  ADDR_W      = 48,
  localparam int IDX_W       = $clog2(NUM_ENTRIES),
  localparam int NP          = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NP-1:0]       rx_sof_i,
  input  logic [NP-1:0]       rx_vld_i,
  input  logic [8*NP-1:0]     rx_byte_i,
  input  logic                cam_we_i,
  input  logic [IDX_W-1:0]    cam_idx_i,
  input  logic                cam_valid_i,
  input  logic [ADDR_W-1:0]   cam_mac_i,
  input  logic [ACT_W-1:0]    cam_act_i,
  input  logic [ACT_W*NP-1:0] miss_act_i,
  input  logic [ACT_W*NP-1:0] flood_act_i,
  input  logic [NP-1:0]       relay_en_i,
  input  logic [NP-1:0]       local_en_i,
  output logic [NP-1:0]       dec_vld_o,
  output logic [ACT_W*NP-1:0] dec_act_o
);
  logic [NUM_ENTRIES-1:0] cam_vld;
  logic [ADDR_W-1:0]      cam_mac [NUM_ENTRIES];
  logic [ACT_W-1:0]       cam_act [NUM_ENTRIES];
  logic [NP-1:0]          go_w;

  dfc_cam_store #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cam_we_i),
    .idx_i   (cam_idx_i),
    .valid_i (cam_valid_i),
    .mac_i   (cam_mac_i),
    .act_i   (cam_act_i),
    .valid_o (cam_vld),
    .mac_o   (cam_mac),
    .act_o   (cam_act)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [ADDR_W-1:0] addr;
    logic              hit;
    logic [ACT_W-1:0]  cact, res;
    logic              s1_vld_q, s1_hit_q, s1_mc_q;
    logic [ACT_W-1:0]  s1_act_q;
    logic              dv_q;
    logic [ACT_W-1:0]  da_q;

    dfc_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sof_i  (rx_sof_i[p]),
      .vld_i  (rx_vld_i[p]),
      .byte_i (rx_byte_i[8*p +: 8]),
      .addr_o (addr),
      .go_o   (go_w[p])
    );

    dfc_cam_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_match (
      .addr_i  (addr),
      .valid_i (cam_vld),
      .mac_i   (cam_mac),
      .act_i   (cam_act),
      .hit_o   (hit),
      .act_o   (cact)
    );

    // stage 1: table result
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_vld_q <= 1'b0;
        s1_hit_q <= 1'b0;
        s1_mc_q  <= 1'b0;
        s1_act_q <= '0;
      end else begin
        s1_vld_q <= go_w[p];
        if (go_w[p]) begin
          s1_hit_q <= hit;
          s1_mc_q  <= addr[ADDR_W-8];
          s1_act_q <= cact;
        end
      end
    end

    dfc_action_resolve u_res (
      .hit_i       (s1_hit_q),
      .mcast_i     (s1_mc_q),
      .cam_act_i   (s1_act_q),
      .miss_act_i  (miss_act_i[ACT_W*p +: ACT_W]),
      .flood_act_i (flood_act_i[ACT_W*p +: ACT_W]),
      .relay_en_i  (relay_en_i[p]),
      .local_en_i  (local_en_i[p]),
      .act_o       (res)
    );

    // stage 2: policy and enables
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dv_q <= 1'b0;
        da_q <= '0;
      end else begin
        dv_q <= s1_vld_q;
        if (s1_vld_q) da_q <= res;
      end
    end

    assign dec_vld_o[p]                 = dv_q;
    assign dec_act_o[ACT_W*p +: ACT_W]  = da_q;
  end
endmodule

// File: rtl/dst_fwd_classifier_chk.sv
module dst_fwd_classifier_chk #(
  parameter int NP = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NP-1:0]   go_i,
  input logic [NP-1:0]   dec_vld_i,
  input logic [2*NP-1:0] dec_act_i,
  input logic [NP-1:0]   relay_en_i,
  input logic [NP-1:0]   local_en_i
);
  for (genvar p = 0; p < NP; p++) begin : g_chk
    a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_i[p] |-> ##2 dec_vld_i[p]);

    a_r2_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_vld_i[p] |=> !dec_vld_i[p]);

    a_r3_no_stray: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_vld_i[p] |-> $past(go_i[p], 2));

    a_r8_relay_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_vld_i[p] && !$past(relay_en_i[p])) |-> !dec_act_i[2*p+1]);

    a_r9_local_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_vld_i[p] && !$past(local_en_i[p])) |-> !dec_act_i[2*p]);
  end
endmodule

bind dst_fwd_classifier dst_fwd_classifier_chk #(.NP(NP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .go_i       (go_w),
  .dec_vld_i  (dec_vld_o),
  .dec_act_i  (dec_act_o),
  .relay_en_i (relay_en_i),
  .local_en_i (local_en_i)
);

// File: tb/dst_fwd_classifier_test.sv
`timescale 1ns/1ps
module dst_fwd_classifier_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic       sof_b [2];
  logic       vld_b [2];
  logic [7:0] byt_b [2];
  logic [1:0] miss_b [2];
  logic [1:0] flood_b [2];
  logic [1:0] ren_b, len_b;
  logic        we;
  logic [4:0]  widx;
  logic        wval;
  logic [47:0] wmac;
  logic [1:0]  wact;
  logic [1:0]  dec_vld;
  logic [3:0]  dec_act;

  logic [47:0] m_mac [32];
  logic        m_val [32];
  logic [1:0]  m_act [32];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dst_fwd_classifier uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rx_sof_i    ({sof_b[1], sof_b[0]}),
    .rx_vld_i    ({vld_b[1], vld_b[0]}),
    .rx_byte_i   ({byt_b[1], byt_b[0]}),
    .cam_we_i    (we),
    .cam_idx_i   (widx),
    .cam_valid_i (wval),
    .cam_mac_i   (wmac),
    .cam_act_i   (wact),
    .miss_act_i  ({miss_b[1], miss_b[0]}),
    .flood_act_i ({flood_b[1], flood_b[0]}),
    .relay_en_i  (ren_b),
    .local_en_i  (len_b),
    .dec_vld_o   (dec_vld),
    .dec_act_o   (dec_act)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] model(int p, logic [47:0] a);
    logic [1:0] r;
    bit found;
    found = 0;
    r = miss_b[p];
    if (a[40]) r = flood_b[p];
    else
      for (int i = 0; i < 32; i++)
        if (!found && m_val[i] && m_mac[i] == a) begin
          r = m_act[i];
          found = 1;
        end
    if (!ren_b[p]) r = (r == 2'b00) ? 2'b00 : 2'b01;
    if (!len_b[p]) r[0] = 1'b0;
    return r;
  endfunction

  task automatic cam_wr(int idx, bit v, logic [47:0] mac, logic [1:0] a);
    @(negedge clk);
    we = 1; widx = 5'(idx); wval = v; wmac = mac; wact = a;
    @(negedge clk);
    we = 0;
    m_val[idx] = v; m_mac[idx] = mac; m_act[idx] = a;
  endtask

  task automatic send(int p, logic [47:0] a, int gap, int extra, string tag);
    logic [1:0] exp;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sof_b[p] = (i == 0); vld_b[p] = 1; byt_b[p] = a[47-8*i -: 8];
      if (i < 5)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          sof_b[p] = 0; vld_b[p] = 0;
        end
    end
    exp = model(p, a);
    for (int k = 1; k <= 4 + extra; k++) begin
      @(negedge clk);
      if (k == 3) begin
        chk(dec_vld[p] == 1'b1, "R2", "strobe at edge k+2", dec_vld[p], 1);
        chk(dec_act[2*p +: 2] == exp, tag, "action", dec_act[2*p +: 2], exp);
      end else begin
        chk(dec_vld[p] == 1'b0, (k < 3) ? "R2" : "R3", "no strobe", dec_vld[p], 0);
      end
      sof_b[p] = 0;
      vld_b[p] = (k <= extra);
      byt_b[p] = 8'($urandom);
    end
    vld_b[p] = 0;
  endtask

  function automatic logic [47:0] rnd_uni();
    logic [47:0] a;
    a = {16'($urandom), 32'($urandom)};
    a[40] = 1'b0;
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b;
    void'($urandom(32'd20240611));
    for (int p = 0; p < 2; p++) begin
      sof_b[p] = 0; vld_b[p] = 0; byt_b[p] = 0;
      miss_b[p] = 2'b01; flood_b[p] = 2'b11;
    end
    ren_b = 2'b11; len_b = 2'b11;
    we = 0; widx = 0; wval = 0; wmac = 0; wact = 0;
    for (int i = 0; i < 32; i++) begin m_val[i] = 0; m_mac[i] = 0; m_act[i] = 0; end

    // R12: reset
    repeat (3) @(negedge clk);
    chk(dec_vld == 2'b00, "R12", "strobe in reset", dec_vld, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(dec_vld == 2'b00, "R12", "strobe after reset", dec_vld, 0);

    // R1: bytes without a valid start marker are ignored
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sof_b[0] = 0; vld_b[0] = 1; byt_b[0] = 8'(i);
    end
    @(negedge clk);
    sof_b[0] = 1; vld_b[0] = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      sof_b[0] = 0; vld_b[0] = 1;
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      vld_b[0] = 0;
      chk(dec_vld[0] == 1'b0, "R1", "no address without start", dec_vld[0], 0);
    end

    // R10/R6: table empty after reset, so miss policy applies
    miss_b[0] = 2'b10;
    send(0, 48'h0200_1122_3344, 0, 0, "R10");

    // R4, R8, R9: every action under every enable pair
    for (int act = 0; act < 4; act++)
      for (int en = 0; en < 4; en++) begin
        miss_b[0] = 2'(act); ren_b[0] = en[0]; len_b[0] = en[1];
        send(0, rnd_uni(), 0, 0, (en == 3) ? "R4" : (en[0] ? "R9" : "R8"));
      end
    ren_b = 2'b11; len_b = 2'b11; miss_b[0] = 2'b00; miss_b[1] = 2'b00;

    // R5: hit and lowest-index priority
    a = 48'h0a0b_0c0d_0e0f;
    cam_wr(7, 1, a, 2'b10);
    send(0, a, 0, 0, "R5");
    cam_wr(3, 1, a, 2'b11);
    send(0, a, 0, 0, "R5");
    send(1, a, 0, 0, "R5");

    // R6: invalid entry never matches
    b = 48'h0a0b_0c0d_0e10;
    cam_wr(0, 0, b, 2'b11);
    miss_b[0] = 2'b01;
    send(0, b, 0, 0, "R6");

    // R7: group addresses use flood even when the table holds them
    b = 48'h0100_5e00_0001;
    cam_wr(1, 1, b, 2'b00);
    flood_b[0] = 2'b10;
    send(0, b, 0, 0, "R7");
    flood_b[0] = 2'b11;
    send(0, 48'hffff_ffff_ffff, 0, 0, "R7");

    // R3: trailing bytes and restart partway through
    send(0, a, 0, 5, "R3");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sof_b[0] = (i == 0); vld_b[0] = 1; byt_b[0] = a[47-8*i -: 8];
    end
    miss_b[0] = 2'b10;
    send(0, 48'h0033_4455_6677, 0, 0, "R3");

    // R2: idle gaps between address bytes
    send(0, a, 2, 0, "R2");
    send(1, 48'h0000_0000_0001, 3, 1, "R2");

    // R11: both ports at once with different settings
    miss_b[0] = 2'b11; miss_b[1] = 2'b11; ren_b = 2'b10; len_b = 2'b01;
    fork
      send(0, 48'h0044_0000_0000, 0, 0, "R11");
      send(1, a, 1, 2, "R11");
    join
    ren_b = 2'b11; len_b = 2'b11;

    // random phase
    for (int i = 0; i < 32; i++)
      cam_wr(i, ($urandom % 5) != 0, rnd_uni(), 2'($urandom));
    cam_wr(20, 1, m_mac[4], 2'($urandom));
    for (int n = 0; n < 300; n++) begin
      int p, sel;
      p = int'($urandom % 2);
      sel = int'($urandom % 10);
      if (sel < 4) a = m_mac[$urandom % 32];
      else if (sel < 6) begin a = rnd_uni(); a[40] = 1'b1; end
      else a = rnd_uni();
      miss_b[p] = 2'($urandom); flood_b[p] = 2'($urandom);
      ren_b[p] = 1'($urandom); len_b[p] = 1'($urandom);
      if (($urandom % 4) == 0) begin ren_b[p] = 1; len_b[p] = 1; end
      send(p, a, int'($urandom % 3), int'($urandom % 4),
           (sel < 4) ? "R5" : (sel < 6) ? "R7" : "R6");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule